// File: doc/BRIEF.md
# Random Word Register Interface

This block is the register-side face of a hardware random number source. An upstream generator delivers 32-bit words over a valid/ready stream. The block gathers four accepted words into one datum and then raises a ready flag. It freezes that datum, and holds the stream off, until software acknowledges it. After the acknowledge it waits a programmable minimum number of cycles before it takes new words. If the datum is still incomplete after a programmable maximum number of cycles, it raises a sticky late flag.

The same register space holds a control register, a refill-timing configuration register and a read-only revision word. Health events from an external test block arrive as single-cycle pulses. Each event sets its own sticky status bit, and a control mask combines those bits into one interrupt line. A test mode cuts off the upstream stream, so that software writes to the first word offset feed the datum instead.

Top module: `rngif_regs`

## Requirements
- R1: After reset the status, control and configuration registers read 0, src_ready is 0 and irq is 0.
- R2: Register map, by byte address: data words at 0x00, 0x04, 0x08 and 0x0C; status at 0x10; control at 0x14; configuration at 0x18; revision at 0x7C. Control keeps only bits 10, 8 and 7:1, and the other bits read 0. Configuration holds the maximum refill count in bits 31:16 and the minimum in bits 7:0. Revision reads major in 27:24, minor in 23:20 and patch in 19:16 (default 0x01230000). Any other address reads 0.
- R3: Accepted words fill the data slots in order 0 to 3. Status bit 0 (ready) sets at the clock edge that accepts the fourth word.
- R4: While ready is set, src_ready stays 0 and the four data words do not change.
- R5: Writing 1 to status bit 0 clears ready, drops any partly collected words and restarts the refill timer.
- R6: With control bit 10 set, src_ready rises exactly `min` clock edges after the arming edge. The arming edge is the acknowledge write, or the edge at which the generator becomes enabled.
- R7: With a nonzero `max`, status bit 8 (late) sets when `max` cycles pass after arming without a complete datum. It stays set until a 1 is written to status bit 8.
- R8: A pulse on health_evt[k] sets status bit k+1. The bit stays set until a 1 is written to it. If a set and a clear arrive in the same cycle, the set wins.
- R9: irq is the OR of status bits 7:1, each ANDed with control bit of the same index. Neither ready nor late raises irq.
- R10: While control bit 10 is 0 the generator is off: ready reads 0, partial words are dropped and src_ready is 0.
- R11: With control bits 10 and 8 set (test mode), src_ready is 0 and the upstream stream is ignored. Each write to address 0x00 is taken as the next word of the datum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_valid | input | 1 | Upstream word valid |
| src_data | input | 32 | Upstream random word |
| src_ready | output | 1 | Block accepts an upstream word this cycle |
| health_evt | input | 7 | Health event pulses, mapped to status bits 7:1 |
| irq | output | 1 | Masked event interrupt |

## Verification
A read responds in the same cycle as its address. Every register write, word accept and event pulse shows up in the cycle after the clock edge that samples it. src_ready rises on the `min`-th edge after arming. The bench drives inputs on falling edges and samples every output 5 ns after each rising edge, when all of these values have settled. There it compares bus_rdata, src_ready and irq against a behavioural model advanced on the same edge. The directed checks count edges from the arming write, so an off-by-one in the refill timer or in late detection shows up as a wrong cycle number rather than a missing value.

// File: rtl/rngif_pkg.sv
package rngif_pkg;
  // byte offsets that software and the test mode rely on
  localparam int OFS_WORD0 = 'h00;
  localparam int OFS_STAT  = 'h10;
  localparam int OFS_CTRL  = 'h14;
  localparam int OFS_CFG   = 'h18;
  localparam int OFS_REV   = 'h7C;

  localparam int EVT_N     = 7;    // status bits 7:1
  localparam int CTRL_EN   = 10;
  localparam int CTRL_TEST = 8;
  localparam int STAT_LATE = 8;
  localparam logic [31:0] CTRL_KEEP = 32'h0000_05FE;

  // refill window is open once the elapsed count reaches the minimum
  function automatic logic pace_open(input logic [31:0] elapsed, input logic [31:0] min_c);
    return elapsed >= min_c;
  endfunction

  function automatic logic irq_of(input logic [EVT_N-1:0] evt, input logic [EVT_N-1:0] ie);
    return |(evt & ie);
  endfunction
endpackage

// File: rtl/rngif_pacer.sv
module rngif_pacer
  import rngif_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int MINC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              hold,
  input  logic              restart,
  input  logic [MINC_W-1:0] min_c,
  input  logic [CNT_W-1:0]  max_c,
  input  logic              fill_done,
  input  logic              late_clr,
  output logic              open,
  output logic              late
);
  logic [CNT_W-1:0] elapsed_q;
  logic             late_set;

  assign open = en & ~hold & pace_open(32'(elapsed_q), 32'(min_c));
  assign late_set = en & ~hold & ~restart & (max_c != '0) &
                    (elapsed_q == max_c) & ~fill_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 elapsed_q <= '0;
    else if (!en || restart)    elapsed_q <= '0;
    else if (!hold && elapsed_q != '1) elapsed_q <= elapsed_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        late <= 1'b0;
    else if (late_set) late <= 1'b1;
    else if (late_clr) late <= 1'b0;
  end
endmodule

// File: rtl/rngif_collect.sv
module rngif_collect #(
  parameter int DATA_W = 32,
  parameter int NWORDS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     ack,
  input  logic                     open,
  input  logic                     cap_v,
  input  logic [DATA_W-1:0]        cap_d,
  output logic                     fire,
  output logic                     fill_done,
  output logic                     datum_rdy,
  output logic [NWORDS*DATA_W-1:0] datum_flat
);
  localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NWORDS - 1);

  logic [IDX_W-1:0] idx_q;
  logic             take;

  assign fire      = open & cap_v;
  assign fill_done = fire & (idx_q == LAST);
  assign take      = en & ~ack & fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q     <= '0;
      datum_rdy <= 1'b0;
    end else if (!en || ack) begin
      idx_q     <= '0;
      datum_rdy <= 1'b0;
    end else if (fire) begin
      idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
      if (idx_q == LAST) datum_rdy <= 1'b1;
    end
  end

  for (genvar g = 0; g < NWORDS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               datum_flat[g*DATA_W +: DATA_W] <= '0;
      else if (take && idx_q == IDX_W'(g))      datum_flat[g*DATA_W +: DATA_W] <= cap_d;
    end
  end
endmodule

// File: rtl/rngif_csr.sv
module rngif_csr
  import rngif_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int NWORDS = 4,
  parameter int CNT_W  = 16,
  parameter int MINC_W = 8,
  parameter logic [3:0] REV_MAJOR = 4'd1,
  parameter logic [3:0] REV_MINOR = 4'd2,
  parameter logic [3:0] REV_PATCH = 4'd3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [EVT_N-1:0]         health_evt,
  input  logic                     late,
  input  logic                     datum_rdy,
  input  logic [NWORDS*DATA_W-1:0] datum_flat,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     en,
  output logic                     test_mode,
  output logic [MINC_W-1:0]        min_c,
  output logic [CNT_W-1:0]         max_c,
  output logic                     ack,
  output logic                     late_clr,
  output logic                     irq
);
  logic [DATA_W-1:0] ctrl_q;
  logic [EVT_N-1:0]  evt_q;
  logic [EVT_N-1:0]  evt_clr;
  logic hit_stat, hit_ctrl, hit_cfg;

  assign hit_stat = wr_en && addr == ADDR_W'(OFS_STAT);
  assign hit_ctrl = wr_en && addr == ADDR_W'(OFS_CTRL);
  assign hit_cfg  = wr_en && addr == ADDR_W'(OFS_CFG);

  assign ack       = hit_stat & wr_data[0];
  assign late_clr  = hit_stat & wr_data[STAT_LATE];
  assign evt_clr   = hit_stat ? wr_data[EVT_N:1] : '0;
  assign en        = ctrl_q[CTRL_EN];
  assign test_mode = ctrl_q[CTRL_TEST];
  assign irq       = irq_of(evt_q, ctrl_q[EVT_N:1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctrl_q <= '0;
    else if (hit_ctrl) ctrl_q <= wr_data & DATA_W'(CTRL_KEEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_c <= '0;
      max_c <= '0;
    end else if (hit_cfg) begin
      min_c <= wr_data[0 +: MINC_W];
      max_c <= wr_data[16 +: CNT_W];
    end
  end

  // sticky events: a new pulse wins over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= (evt_q & ~evt_clr) | health_evt;
  end

  always_comb begin
    rd_data = '0;
    if (addr == ADDR_W'(OFS_STAT)) begin
      rd_data[0]         = datum_rdy;
      rd_data[EVT_N:1]   = evt_q;
      rd_data[STAT_LATE] = late;
    end else if (addr == ADDR_W'(OFS_CTRL)) begin
      rd_data = ctrl_q;
    end else if (addr == ADDR_W'(OFS_CFG)) begin
      rd_data[0 +: MINC_W] = min_c;
      rd_data[16 +: CNT_W] = max_c;
    end else if (addr == ADDR_W'(OFS_REV)) begin
      rd_data[27:24] = REV_MAJOR;
      rd_data[23:20] = REV_MINOR;
      rd_data[19:16] = REV_PATCH;
    end else begin
      for (int k = 0; k < NWORDS; k++)
        if (addr == ADDR_W'(OFS_WORD0 + 4 * k)) rd_data = datum_flat[k*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/rngif_regs.sv
module rngif_regs
  import rngif_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int NWORDS = 4,
  parameter int CNT_W  = 16,
  parameter int MINC_W = 8,
  parameter logic [3:0] REV_MAJOR = 4'd1,
  parameter logic [3:0] REV_MINOR = 4'd2,
  parameter logic [3:0] REV_PATCH = 4'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  input  logic [EVT_N-1:0]  health_evt,
  output logic              irq
);
  // named internal events, also watched by the bound checker
  logic                     ctl_en, ctl_test;
  logic                     ack_hit, late_clr, late_flag;
  logic                     win_open, cap_v, cap_fire, fill_done, datum_rdy;
  logic [DATA_W-1:0]        cap_d;
  logic [MINC_W-1:0]        min_c;
  logic [CNT_W-1:0]         max_c;
  logic [NWORDS*DATA_W-1:0] datum_flat;

  assign cap_v     = ctl_test ? (bus_wr && bus_addr == ADDR_W'(OFS_WORD0)) : src_valid;
  assign cap_d     = ctl_test ? bus_wdata : src_data;
  assign src_ready = win_open & ~ctl_test;

  rngif_csr #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NWORDS(NWORDS), .CNT_W(CNT_W), .MINC_W(MINC_W),
    .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR), .REV_PATCH(REV_PATCH)
  ) u_csr (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wr_data(bus_wdata),
    .health_evt(health_evt), .late(late_flag), .datum_rdy(datum_rdy), .datum_flat(datum_flat),
    .rd_data(bus_rdata), .en(ctl_en), .test_mode(ctl_test), .min_c(min_c), .max_c(max_c),
    .ack(ack_hit), .late_clr(late_clr), .irq(irq)
  );

  rngif_pacer #(.CNT_W(CNT_W), .MINC_W(MINC_W)) u_pacer (
    .clk(clk), .rst_n(rst_n), .en(ctl_en), .hold(datum_rdy), .restart(ack_hit),
    .min_c(min_c), .max_c(max_c), .fill_done(fill_done), .late_clr(late_clr),
    .open(win_open), .late(late_flag)
  );

  rngif_collect #(.DATA_W(DATA_W), .NWORDS(NWORDS)) u_collect (
    .clk(clk), .rst_n(rst_n), .en(ctl_en), .ack(ack_hit), .open(win_open),
    .cap_v(cap_v), .cap_d(cap_d), .fire(cap_fire), .fill_done(fill_done),
    .datum_rdy(datum_rdy), .datum_flat(datum_flat)
  );
endmodule

// File: rtl/rngif_regs_chk.sv
module rngif_regs_chk #(
  parameter int DATA_W = 32,
  parameter int NWORDS = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     en,
  input logic                     ack,
  input logic                     fire,
  input logic                     datum_rdy,
  input logic                     src_ready,
  input logic                     late,
  input logic                     late_clr,
  input logic [NWORDS*DATA_W-1:0] datum_flat
);
  a_r4_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    datum_rdy |-> !src_ready);

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    datum_rdy && en && !ack |=> $stable(datum_flat));

  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    en && ack |=> !datum_rdy);

  a_r10_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !datum_rdy);

  a_r3_fill: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(datum_rdy) |-> $past(fire));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    late && !late_clr |=> late);
endmodule

bind rngif_regs rngif_regs_chk #(.DATA_W(DATA_W), .NWORDS(NWORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(ctl_en), .ack(ack_hit), .fire(cap_fire),
  .datum_rdy(datum_rdy), .src_ready(src_ready), .late(late_flag),
  .late_clr(late_clr), .datum_flat(datum_flat)
);

// File: tb/rngif_regs_test.sv
module rngif_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        src_valid = 1'b0;
  logic [31:0] src_data = 32'h1234_5678;
  logic        src_ready;
  logic [6:0]  health_evt = 7'h0;
  logic        irq;

  int vectors = 0;
  int fails = 0;
  int cyc_n = 0;
  bit done = 0;

  always #10 clk = ~clk;   // 50 MHz

  rngif_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .health_evt(health_evt), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h (t=%0t)", tag, got, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  bit [31:0] m_ctrl;
  int        m_min, m_max, m_el;
  bit [7:1]  m_evt;
  bit        m_rdy, m_late;
  bit [31:0] m_q[$];
  bit [31:0] m_dat[4];

  function automatic bit [31:0] m_read(input bit [7:0] a);
    case (a)
      8'h00, 8'h04, 8'h08, 8'h0C: return m_dat[a >> 2];
      8'h10: return {23'b0, m_late, m_evt, m_rdy};
      8'h14: return m_ctrl;
      8'h18: return {m_max[15:0], 8'h00, m_min[7:0]};
      8'h7C: return 32'h0123_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input bit [7:0] a);
    if (a < 8'h10) return "R3 word";
    if (a == 8'h10) return "R5 status";
    return "R2 register";
  endfunction

  bit        s_en, s_tm, s_opn, s_hs, s_ack, s_pv, s_took, s_done4;
  bit [31:0] s_pd;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_min = 0; m_max = 0; m_el = 0; m_evt = 0;
      m_rdy = 0; m_late = 0; m_q.delete();
      for (int k = 0; k < 4; k++) m_dat[k] = 0;
    end else begin
      s_en    = m_ctrl[10];
      s_tm    = m_ctrl[8];
      s_opn   = s_en && !m_rdy && (m_el >= m_min);
      s_hs    = bus_wr && bus_addr == 8'h10;
      s_ack   = s_hs && bus_wdata[0];
      s_pv    = s_tm ? (bus_wr && bus_addr == 8'h00) : src_valid;
      s_pd    = s_tm ? bus_wdata : src_data;
      s_took  = s_opn && s_pv;
      s_done4 = s_took && m_q.size() == 3;
      if (s_en && !m_rdy && !s_ack && m_max != 0 && m_el == m_max && !s_done4) m_late = 1;
      else if (s_hs && bus_wdata[8]) m_late = 0;
      for (int i = 1; i <= 7; i++)
        m_evt[i] = (m_evt[i] && !(s_hs && bus_wdata[i])) || health_evt[i-1];
      if (!s_en || s_ack) begin
        m_rdy = 0; m_q.delete(); m_el = 0;
      end else begin
        if (!m_rdy && m_el < 65535) m_el++;
        if (s_took) begin
          m_dat[m_q.size()] = s_pd;
          m_q.push_back(s_pd);
          if (m_q.size() == 4) begin m_q.delete(); m_rdy = 1; end
        end
      end
      if (bus_wr && bus_addr == 8'h14) m_ctrl = bus_wdata & 32'h0000_05FE;
      if (bus_wr && bus_addr == 8'h18) begin
        m_min = int'(bus_wdata[7:0]);
        m_max = int'(bus_wdata[31:16]);
      end
    end
  end

  // per-cycle comparison, 5 ns after each rising edge
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) begin
      check("R6 src_ready", {31'b0, src_ready},
            {31'b0, m_ctrl[10] && !m_ctrl[8] && !m_rdy && (m_el >= m_min)});
      check("R9 irq", {31'b0, irq}, {31'b0, |(m_evt & m_ctrl[7:1])});
      check(tag_of(bus_addr), bus_rdata, m_read(bus_addr));
    end
  end

  // upstream word source and watchdog
  always @(negedge clk) src_data = src_data * 32'h9E37_79B1 + 32'd1;

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n > 5000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not finish, got cycle %0d expected below 5000", cyc_n);
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    #6;
    v = bus_rdata;
  endtask

  logic [31:0] v, v2;
  int k;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h10, v); check("R1 status after reset", v, 32'h0);
    rd(8'h14, v); check("R1 control after reset", v, 32'h0);
    rd(8'h18, v); check("R1 config after reset", v, 32'h0);
    check("R1 src_ready after reset", {31'b0, src_ready}, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);

    // R2 map
    rd(8'h7C, v); check("R2 revision", v, 32'h0123_0000);
    rd(8'h40, v); check("R2 unmapped", v, 32'h0);
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, v); check("R2 control keep mask", v, 32'h0000_05FE);
    wr(8'h14, 32'h0);
    wr(8'h18, 32'h0028_0003);
    rd(8'h18, v); check("R2 config fields", v, 32'h0028_0003);

    // R6 minimum refill gap after enabling
    src_valid = 1'b1;
    wr(8'h14, 32'h0000_04FE);
    k = 0;
    do begin @(posedge clk); #6; k++; end while (!src_ready && k < 20);
    check("R6 edges to src_ready", k, 3);

    // R3 ready after four words
    repeat (8) @(negedge clk);
    rd(8'h10, v); check("R3 ready flag", v, 32'h1);

    // R4 hold while ready
    rd(8'h00, v);
    repeat (5) @(negedge clk);
    rd(8'h00, v2);
    check("R4 word stable", v2, v);
    check("R4 src_ready low", {31'b0, src_ready}, 32'h0);

    // R5 acknowledge
    wr(8'h10, 32'h1);
    rd(8'h10, v); check("R5 ready cleared", v, 32'h0);

    // R7 late flag
    src_valid = 1'b0;
    wr(8'h18, 32'h000A_0000);
    wr(8'h10, 32'h1);
    repeat (20) @(negedge clk);
    rd(8'h10, v); check("R7 late set", v, 32'h100);
    wr(8'h10, 32'h100);
    rd(8'h10, v); check("R7 late cleared", v, 32'h0);

    // R8 / R9 events and interrupt
    @(negedge clk); health_evt = 7'b000_0100;
    @(negedge clk); health_evt = 7'h0;
    rd(8'h10, v); check("R8 event bit 3", v, 32'h008);
    check("R9 irq enabled", {31'b0, irq}, 32'h1);
    wr(8'h14, 32'h0000_0400);
    rd(8'h10, v); check("R8 event held", v, 32'h008);
    check("R9 irq masked", {31'b0, irq}, 32'h0);
    wr(8'h14, 32'h0000_04FE);
    wr(8'h10, 32'h008);
    rd(8'h10, v); check("R8 event cleared", v, 32'h0);
    @(negedge clk);
    health_evt = 7'b000_0001; bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h2;
    @(negedge clk);
    health_evt = 7'h0; bus_wr = 1'b0;
    rd(8'h10, v); check("R8 set wins over clear", v, 32'h002);
    wr(8'h10, 32'h002);

    // R10 disable drops the datum
    wr(8'h18, 32'h0);
    src_valid = 1'b1;
    wr(8'h10, 32'h1);
    repeat (8) @(negedge clk);
    rd(8'h10, v); check("R10 ready before disable", v, 32'h1);
    wr(8'h14, 32'h0);
    rd(8'h10, v); check("R10 ready after disable", v, 32'h0);
    check("R10 src_ready off", {31'b0, src_ready}, 32'h0);

    // R11 test mode feeds words through address 0x00
    wr(8'h14, 32'h0000_05FE);
    @(negedge clk); #1;
    check("R11 upstream blocked", {31'b0, src_ready}, 32'h0);
    wr(8'h00, 32'hA5A5_0001);
    wr(8'h00, 32'hA5A5_0002);
    wr(8'h00, 32'hA5A5_0003);
    wr(8'h00, 32'hA5A5_0004);
    rd(8'h00, v); check("R11 slot 0", v, 32'hA5A5_0001);
    rd(8'h04, v); check("R11 slot 1", v, 32'hA5A5_0002);
    rd(8'h08, v); check("R3 slot 2 order", v, 32'hA5A5_0003);
    rd(8'h0C, v); check("R3 slot 3 order", v, 32'hA5A5_0004);
    rd(8'h10, v); check("R3 ready in test mode", v, 32'h1);
    check("R9 ready alone gives no irq", {31'b0, irq}, 32'h0);

    done = 1;
    finish_run();
  end
endmodule